// File: doc/BRIEF.md
# Stage-1 Address Region Pre-Check Unit

This unit sits in front of a stage-1 address translation engine. Each cycle it can accept one request: a 64-bit virtual address, a user/kernel flag, an instruction-fetch flag, a non-faulting-access flag, the TLB hit result for that address, a 64-bit translation control word and the two candidate ASIDs. It picks the lower or the upper translation region from the address, decodes that region's granule code and checks the address against the region's size limits. It then returns exactly one outcome: a level-0 translation fault, a walk-disabled fault, a silent non-fault failure, a walk request, or nothing when the TLB hit and no fault applies.

Alongside the outcome it gives the address after top-byte handling, an unchecked-tag flag, the ASID to be used for matching and the level at which a walk would start. Every result is registered, so all outcomes, faults included, arrive on the same cycle after the request. This holds whether or not the TLB hit, which keeps the fault timing from revealing TLB contents. The table walk itself, the TLB storage and descriptor handling belong to other blocks.

Top module: `s1_region_precheck`

## Requirements
- R1: Every accepted request (`req_valid` high at a rising edge) produces `rsp_valid` high and all its results on the next rising edge, with no exception for faults or TLB hits. `rsp_valid` is low in any cycle after a cycle with no request, and all outputs are zero after reset.
- R2: The control word holds the lower-region fields in bits [13:0] and the upper-region fields in bits [27:14]. Each region's fields are laid out as follows: size offset TxSZ [5:0], granule code [7:6], walk-off [8], user-fault [9], non-fault timing [10], top-byte ignore [11], top-byte data-only [12], tag-check override [13]. Large-address mode is bit 28, ASID-from-upper is bit 29 and 16-bit ASID is bit 30. The upper region is used when address bit 55 is 1, and `rsp_region_hi` reports the choice.
- R3: `rsp_granule` uses the codes 0 for 4KB, 1 for 16KB and 2 for 64KB. The lower-region code maps 00 to 4KB, 01 to 64KB and 10 to 16KB. The upper-region code maps 10 to 4KB, 01 to 16KB and 11 to 64KB. The remaining code of each region maps to the size set by parameter `FALLBACK_GRAN`, which defaults to 4KB.
- R4: A TxSZ below 16 raises `rsp_fault_l0` when large-address mode is 0. With large-address mode 1, only a TxSZ below 12 faults.
- R5: A region spans 2^(64-TxSZ) bytes. Every address bit from position 64-TxSZ up to bit 63 must equal bit 55, or `rsp_fault_l0` is raised. When top-byte ignore is in effect, bits [63:56] are left out of this comparison.
- R6: A user-mode access to a region whose user-fault bit is 1 raises `rsp_fault_l0` whether the TLB hit or missed. It raises no walk request.
- R7: On a TLB miss in a region whose walk-off bit is 1 and with no level-0 fault, `rsp_fault_walkoff` is raised and no walk request is made. A TLB hit raises no walk-off fault.
- R8: A user-mode non-faulting access that misses the TLB in a region whose non-fault timing bit is 1 raises `rsp_nf_fail` instead of a walk request. This applies only when there is no level-0 or walk-off fault. A hit or a kernel access does not raise it.
- R9: `rsp_walk_req` is raised only for a TLB miss with no fault and no non-fault failure. At most one of the four outcome flags is high in a response.
- R10: Top-byte ignore is in effect when the region's ignore bit is 1, unless its data-only bit is also 1 and the access is an instruction fetch. While it is in effect, `rsp_eff_addr` bits [63:56] are copies of bit 55. Otherwise the address passes through unchanged.
- R11: `rsp_unchecked` is 1 when the region's tag-check override bit is 1 and address bits [59:55] are all ones in the upper region or all zeros in the lower region.
- R12: `rsp_asid` is taken from `hi_asid` when the ASID-from-upper bit is 1 and from `lo_asid` otherwise. Its bits [15:8] are forced to zero when the 16-bit ASID bit is 0.
- R13: `rsp_start_lvl` holds the first walk level plus one. The level is 4 minus ceil((64-TxSZ-P)/S), with P,S = 12,9 for 4KB, 14,11 for 16KB and 16,13 for 64KB. So 4KB with TxSZ 12 starts at level -1 (code 0), and 16KB with TxSZ 17 starts at level 1 (code 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_user | input | 1 | 1 = user-mode access |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_nonfault | input | 1 | 1 = non-faulting access type |
| tlb_hit | input | 1 | TLB hit for this address |
| tcw | input | 64 | Translation control word |
| lo_asid | input | 16 | ASID from lower-region base register |
| hi_asid | input | 16 | ASID from upper-region base register |
| rsp_valid | output | 1 | Results valid |
| rsp_region_hi | output | 1 | Upper region selected |
| rsp_granule | output | 2 | Normalised granule code |
| rsp_start_lvl | output | 3 | Starting walk level plus one |
| rsp_fault_l0 | output | 1 | Level-0 translation fault |
| rsp_fault_walkoff | output | 1 | Walk-disabled translation fault |
| rsp_nf_fail | output | 1 | Silent non-fault failure |
| rsp_walk_req | output | 1 | Table walk required |
| rsp_eff_addr | output | 64 | Address after top-byte handling |
| rsp_unchecked | output | 1 | Access is tag-unchecked |
| rsp_asid | output | 16 | ASID for matching |

## Verification
Every result of a request is due on the first rising edge after the request is sampled: one register stage, the same for faults, failures, walks and hits. The driver sets a request on a falling edge and queues its predicted results. The monitor takes the oldest prediction on the falling edge that follows that rising edge, whenever `rsp_valid` is high, so each comparison falls half a period after the outputs settle. Back-to-back requests and idle gaps are mixed in. A response with nothing queued, or predictions left over at the end, is reported against the fixed-latency requirement.

// File: rtl/s1pc_pkg.sv
package s1pc_pkg;

  localparam int VA_W   = 64;
  localparam int ASID_W = 16;

  typedef enum logic [1:0] {
    GR_4K  = 2'd0,
    GR_16K = 2'd1,
    GR_64K = 2'd2
  } gran_e;

  // Per-region control fields, 14 bits, LSB last.
  typedef struct packed {
    logic       tag_ovr;
    logic       tbi_donly;
    logic       tbi;
    logic       nf_tmg;
    logic       user_flt;
    logic       walk_off;
    logic [1:0] gran;
    logic [5:0] txsz;
  } rgn_ctl_t;

  typedef struct packed {
    logic [32:0] spare;
    logic        asid16;
    logic        asid_hi_sel;
    logic        big_addr;
    rgn_ctl_t    hi;
    rgn_ctl_t    lo;
  } tcw_t;

  typedef struct packed {
    logic              hi;
    gran_e             gran;
    logic [2:0]        lvl;
    logic              l0;
    logic              walkoff;
    logic              nf;
    logic              walk;
    logic [VA_W-1:0]   eff;
    logic              unch;
    logic [ASID_W-1:0] asid;
  } rsp_t;

  function automatic int page_bits(gran_e g);
    case (g)
      GR_16K:  return 14;
      GR_64K:  return 16;
      default: return 12;
    endcase
  endfunction

  function automatic int level_bits(gran_e g);
    case (g)
      GR_16K:  return 11;
      GR_64K:  return 13;
      default: return 9;
    endcase
  endfunction

endpackage

// File: rtl/s1pc_gran_dec.sv
module s1pc_gran_dec
  import s1pc_pkg::*;
#(
  parameter bit    UPPER    = 1'b0,
  parameter gran_e FALLBACK = GR_4K
) (
  input  logic [1:0] code,
  output gran_e      gran
);

  generate
    if (UPPER) begin : g_upper
      always_comb begin
        case (code)
          2'b01:   gran = GR_16K;
          2'b10:   gran = GR_4K;
          2'b11:   gran = GR_64K;
          default: gran = FALLBACK;
        endcase
      end
    end else begin : g_lower
      always_comb begin
        case (code)
          2'b00:   gran = GR_4K;
          2'b01:   gran = GR_64K;
          2'b10:   gran = GR_16K;
          default: gran = FALLBACK;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/s1pc_limit_chk.sv
module s1pc_limit_chk
  import s1pc_pkg::*;
#(
  parameter int TB_LO    = 56,
  parameter int MAX_LVLS = 5
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [5:0]      txsz,
  input  logic [5:0]      min_sz,
  input  logic            tbi_eff,
  input  logic            hi,
  input  gran_e           gran,
  output logic            size_flt,
  output logic            range_flt,
  output logic [2:0]      start_code
);

  int         va_bits;
  int         pg;
  int         st;
  logic [2:0] lvl_cnt;

  always_comb begin
    size_flt = (txsz < min_sz);
  end

  // Bits above the region must copy the region select bit.
  always_comb begin
    range_flt = 1'b0;
    for (int b = 0; b < VA_W; b++) begin
      if ((b >= VA_W - int'(txsz)) && !(tbi_eff && (b >= TB_LO)) &&
          (vaddr[b] != hi)) begin
        range_flt = 1'b1;
      end
    end
  end

  // Number of levels needed to resolve the region, then first level.
  always_comb begin
    va_bits = VA_W - int'(txsz);
    pg      = page_bits(gran);
    st      = level_bits(gran);
    lvl_cnt = 3'd1;
    for (int i = 1; i < MAX_LVLS; i++) begin
      if (pg + st * i < va_bits) begin
        lvl_cnt = 3'(i + 1);
      end
    end
    start_code = 3'(MAX_LVLS) - lvl_cnt;
  end

endmodule

// File: rtl/s1pc_tag_xform.sv
module s1pc_tag_xform
  import s1pc_pkg::*;
#(
  parameter int TB_LO  = 56,
  parameter int TAG_HI = 59,
  parameter int SEL_B  = 55
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic            tbi_eff,
  input  logic            tag_ovr,
  input  logic            hi,
  output logic [VA_W-1:0] eff_addr,
  output logic            unchecked
);

  localparam int TB_W  = VA_W - TB_LO;
  localparam int TAG_W = TAG_HI - SEL_B + 1;

  logic [TAG_W-1:0] tag_bits;

  always_comb begin
    eff_addr = vaddr;
    if (tbi_eff) begin
      eff_addr[VA_W-1:TB_LO] = {TB_W{vaddr[SEL_B]}};
    end
  end

  always_comb begin
    tag_bits  = vaddr[TAG_HI:SEL_B];
    unchecked = tag_ovr & (hi ? (&tag_bits) : ~(|tag_bits));
  end

endmodule

// File: rtl/s1_region_precheck.sv
module s1_region_precheck
  import s1pc_pkg::*;
#(
  parameter gran_e FALLBACK_GRAN = GR_4K,
  parameter int    MIN_SZ_STD    = 16,
  parameter int    MIN_SZ_BIG    = 12,
  parameter int    SEL_B         = 55,
  parameter int    TB_LO         = 56,
  parameter int    N_RGN         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_user,
  input  logic              req_fetch,
  input  logic              req_nonfault,
  input  logic              tlb_hit,
  input  logic [63:0]       tcw,
  input  logic [ASID_W-1:0] lo_asid,
  input  logic [ASID_W-1:0] hi_asid,
  output logic              rsp_valid,
  output logic              rsp_region_hi,
  output logic [1:0]        rsp_granule,
  output logic [2:0]        rsp_start_lvl,
  output logic              rsp_fault_l0,
  output logic              rsp_fault_walkoff,
  output logic              rsp_nf_fail,
  output logic              rsp_walk_req,
  output logic [VA_W-1:0]   rsp_eff_addr,
  output logic              rsp_unchecked,
  output logic [ASID_W-1:0] rsp_asid
);

  localparam logic [5:0] MIN_STD = 6'(MIN_SZ_STD);
  localparam logic [5:0] MIN_BIG = 6'(MIN_SZ_BIG);
  localparam int         ASID_LO = ASID_W / 2;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Region select and field decode
  tcw_t     cw;
  rgn_ctl_t rc;
  logic     sel_hi;
  gran_e    gdec [N_RGN];
  gran_e    gran_sel;
  logic     tbi_eff;
  logic [5:0] min_sz;

  assign cw     = tcw_t'(tcw);
  assign sel_hi = req_vaddr[SEL_B];

  generate
    for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
      s1pc_gran_dec #(
        .UPPER    (g == 1),
        .FALLBACK (FALLBACK_GRAN)
      ) u_gdec (
        .code (g == 1 ? cw.hi.gran : cw.lo.gran),
        .gran (gdec[g])
      );
    end
  endgenerate

  always_comb begin
    rc       = sel_hi ? cw.hi : cw.lo;
    gran_sel = gdec[sel_hi];
    tbi_eff  = rc.tbi & ~(rc.tbi_donly & req_fetch);
    min_sz   = cw.big_addr ? MIN_BIG : MIN_STD;
  end

  // Limit checks, start level, address transform
  logic            size_flt;
  logic            range_flt;
  logic [2:0]      start_code;
  logic [VA_W-1:0] eff_addr;
  logic            unchecked;

  s1pc_limit_chk #(
    .TB_LO (TB_LO)
  ) u_limit (
    .vaddr      (req_vaddr),
    .txsz       (rc.txsz),
    .min_sz     (min_sz),
    .tbi_eff    (tbi_eff),
    .hi         (sel_hi),
    .gran       (gran_sel),
    .size_flt   (size_flt),
    .range_flt  (range_flt),
    .start_code (start_code)
  );

  s1pc_tag_xform #(
    .TB_LO (TB_LO),
    .SEL_B (SEL_B)
  ) u_xform (
    .vaddr     (req_vaddr),
    .tbi_eff   (tbi_eff),
    .tag_ovr   (rc.tag_ovr),
    .hi        (sel_hi),
    .eff_addr  (eff_addr),
    .unchecked (unchecked)
  );

  // Outcome priority: level-0 fault, walk-off fault, non-fault fail, walk.
  logic              l0_n;
  logic              wo_n;
  logic              nf_n;
  logic              walk_n;
  logic [ASID_W-1:0] asid_n;

  always_comb begin
    l0_n   = size_flt | range_flt | (req_user & rc.user_flt);
    wo_n   = ~l0_n & ~tlb_hit & rc.walk_off;
    nf_n   = ~l0_n & ~tlb_hit & ~rc.walk_off & req_user & req_nonfault & rc.nf_tmg;
    walk_n = ~l0_n & ~tlb_hit & ~rc.walk_off & ~nf_n;
    asid_n = cw.asid_hi_sel ? hi_asid : lo_asid;
    if (!cw.asid16) begin
      asid_n[ASID_W-1:ASID_LO] = '0;
    end
  end

  // Next state
  rsp_t rsp_d;
  rsp_t rsp_q;
  logic vld_d;
  logic vld_q;

  always_comb begin
    vld_d = req_valid;
    rsp_d = rsp_q;
    if (req_valid) begin
      rsp_d.hi      = sel_hi;
      rsp_d.gran    = gran_sel;
      rsp_d.lvl     = start_code;
      rsp_d.l0      = l0_n;
      rsp_d.walkoff = wo_n;
      rsp_d.nf      = nf_n;
      rsp_d.walk    = walk_n;
      rsp_d.eff     = eff_addr;
      rsp_d.unch    = unchecked;
      rsp_d.asid    = asid_n;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      rsp_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (req_valid) begin
        rsp_q <= rsp_d;
      end
    end
  end

  assign rsp_valid         = vld_q;
  assign rsp_region_hi     = rsp_q.hi;
  assign rsp_granule       = rsp_q.gran;
  assign rsp_start_lvl     = rsp_q.lvl;
  assign rsp_fault_l0      = rsp_q.l0;
  assign rsp_fault_walkoff = rsp_q.walkoff;
  assign rsp_nf_fail       = rsp_q.nf;
  assign rsp_walk_req      = rsp_q.walk;
  assign rsp_eff_addr      = rsp_q.eff;
  assign rsp_unchecked     = rsp_q.unch;
  assign rsp_asid          = rsp_q.asid;

endmodule

// File: rtl/s1pc_checker.sv
module s1pc_checker
  import s1pc_pkg::*;
#(
  parameter int MIN_SZ_STD = 16,
  parameter int MIN_SZ_BIG = 12
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              req_user,
  input logic              tlb_hit,
  input logic [63:0]       tcw,
  input logic              rsp_valid,
  input logic              rsp_region_hi,
  input logic              rsp_fault_l0,
  input logic              rsp_fault_walkoff,
  input logic              rsp_nf_fail,
  input logic              rsp_walk_req,
  input logic [ASID_W-1:0] rsp_asid
);

  tcw_t     c;
  rgn_ctl_t r;
  int       min_sz;

  always_comb begin
    c      = tcw_t'(tcw);
    r      = req_vaddr[55] ? c.hi : c.lo;
    min_sz = c.big_addr ? MIN_SZ_BIG : MIN_SZ_STD;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);

  assert_region_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> (rsp_region_hi == $past(req_vaddr[55])));

  assert_size_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && (int'(r.txsz) < min_sz)) |=> rsp_fault_l0);

  assert_user_flt_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_user && r.user_flt) |=> (rsp_fault_l0 && !rsp_walk_req));

  assert_hit_quiet_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && tlb_hit) |=> (!rsp_walk_req && !rsp_fault_walkoff && !rsp_nf_fail));

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> $onehot0({rsp_fault_l0, rsp_fault_walkoff, rsp_nf_fail, rsp_walk_req}));

  assert_asid8_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !c.asid16) |=> (rsp_asid[ASID_W-1:ASID_W/2] == '0));

endmodule

bind s1_region_precheck s1pc_checker #(
  .MIN_SZ_STD (MIN_SZ_STD),
  .MIN_SZ_BIG (MIN_SZ_BIG)
) i_s1pc_checker (
  .clk               (clk),
  .rst_sync_n        (rst_sync_n),
  .req_valid         (req_valid),
  .req_vaddr         (req_vaddr),
  .req_user          (req_user),
  .tlb_hit           (tlb_hit),
  .tcw               (tcw),
  .rsp_valid         (rsp_valid),
  .rsp_region_hi     (rsp_region_hi),
  .rsp_fault_l0      (rsp_fault_l0),
  .rsp_fault_walkoff (rsp_fault_walkoff),
  .rsp_nf_fail       (rsp_nf_fail),
  .rsp_walk_req      (rsp_walk_req),
  .rsp_asid          (rsp_asid)
);

// File: tb/test_s1_region_precheck.sv
`timescale 1ns/1ps
module test_s1_region_precheck;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_vaddr;
  logic        req_user;
  logic        req_fetch;
  logic        req_nonfault;
  logic        tlb_hit;
  logic [63:0] tcw;
  logic [15:0] lo_asid;
  logic [15:0] hi_asid;
  logic        rsp_valid;
  logic        rsp_region_hi;
  logic [1:0]  rsp_granule;
  logic [2:0]  rsp_start_lvl;
  logic        rsp_fault_l0;
  logic        rsp_fault_walkoff;
  logic        rsp_nf_fail;
  logic        rsp_walk_req;
  logic [63:0] rsp_eff_addr;
  logic        rsp_unchecked;
  logic [15:0] rsp_asid;

  s1_region_precheck i_s1_region_precheck (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_user(req_user), .req_fetch(req_fetch), .req_nonfault(req_nonfault),
    .tlb_hit(tlb_hit), .tcw(tcw), .lo_asid(lo_asid), .hi_asid(hi_asid),
    .rsp_valid(rsp_valid), .rsp_region_hi(rsp_region_hi),
    .rsp_granule(rsp_granule), .rsp_start_lvl(rsp_start_lvl),
    .rsp_fault_l0(rsp_fault_l0), .rsp_fault_walkoff(rsp_fault_walkoff),
    .rsp_nf_fail(rsp_nf_fail), .rsp_walk_req(rsp_walk_req),
    .rsp_eff_addr(rsp_eff_addr), .rsp_unchecked(rsp_unchecked),
    .rsp_asid(rsp_asid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    bit        hi;
    bit [1:0]  gran;
    bit [2:0]  lvl;
    bit        l0, wo, nf, walk;
    bit [63:0] eff;
    bit        unch;
    bit [15:0] asid;
    string     tag;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   mon_on  = 1'b0;
  bit   done    = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Region field packing: tov,donly,tbi,nf,ufl,wo,gran[1:0],txsz[5:0]
  function automatic bit [13:0] rg(input int txsz, input bit [1:0] gc,
      input bit wo = 0, input bit ufl = 0, input bit nf = 0,
      input bit tbi = 0, input bit donly = 0, input bit tov = 0);
    return {tov, donly, tbi, nf, ufl, wo, gc, 6'(txsz)};
  endfunction

  function automatic bit [63:0] mkcw(input bit [13:0] lo, input bit [13:0] hi,
      input bit big = 0, input bit asel = 0, input bit a16 = 1);
    return {33'b0, a16, asel, big, hi, lo};
  endfunction

  function automatic exp_t model(input bit [63:0] va, input bit usr,
      input bit fch, input bit nfl, input bit hit, input bit [63:0] cw,
      input bit [15:0] la, input bit [15:0] ha, input string tag);
    exp_t e;
    bit h = va[55];
    bit [13:0] r = h ? cw[27:14] : cw[13:0];
    int tx = int'(r[5:0]);
    bit [1:0] gc = r[7:6];
    bit tbe = r[11] && !(r[12] && fch);
    int vab = 64 - tx;
    bit bad = 0;
    int pg, st;
    e.tag = tag;
    e.hi  = h;
    if (!h) e.gran = (gc == 2'b01) ? 2'd2 : (gc == 2'b10) ? 2'd1 : 2'd0;
    else    e.gran = (gc == 2'b01) ? 2'd1 : (gc == 2'b11) ? 2'd2 : 2'd0;
    for (int b = vab; b < 64; b++) begin
      if (!(tbe && b >= 56) && va[b] != h) bad = 1;
    end
    e.l0   = (tx < (cw[28] ? 12 : 16)) || bad || (usr && r[9]);
    e.wo   = !e.l0 && !hit && r[8];
    e.nf   = !e.l0 && !hit && !r[8] && usr && nfl && r[10];
    e.walk = !e.l0 && !hit && !r[8] && !e.nf;
    pg = (e.gran == 2'd0) ? 12 : (e.gran == 2'd1) ? 14 : 16;
    st = (e.gran == 2'd0) ? 9  : (e.gran == 2'd1) ? 11 : 13;
    e.lvl  = 3'(5 - (vab - pg + st - 1) / st);
    e.eff  = tbe ? {{8{va[55]}}, va[55:0]} : va;
    e.unch = r[13] && (h ? (va[59:55] == 5'h1f) : (va[59:55] == 5'h00));
    e.asid = cw[29] ? ha : la;
    if (!cw[30]) e.asid[15:8] = 8'h00;
    return e;
  endfunction

  task automatic send(input bit [63:0] va, input bit [63:0] cw,
      input string tag, input bit usr = 0, input bit fch = 0,
      input bit nfl = 0, input bit hit = 0,
      input bit [15:0] la = 16'h1234, input bit [15:0] ha = 16'hABCD);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_user = usr; req_fetch = fch;
    req_nonfault = nfl; tlb_hit = hit; tcw = cw; lo_asid = la; hi_asid = ha;
    q.push_back(model(va, usr, fch, nfl, hit, cw, la, ha, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: results are due one rising edge after the request.
  always @(negedge clk) begin
    if (mon_on && rsp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1 unexpected response", 64'(rsp_valid), 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_region_hi == e.hi, "R2 region", 64'(rsp_region_hi), 64'(e.hi));
        chk(rsp_granule == e.gran, "R3 granule", 64'(rsp_granule), 64'(e.gran));
        chk(rsp_fault_l0 == e.l0, {e.tag, " fault_l0"}, 64'(rsp_fault_l0), 64'(e.l0));
        chk(rsp_fault_walkoff == e.wo, {e.tag, " walkoff"}, 64'(rsp_fault_walkoff), 64'(e.wo));
        chk(rsp_nf_fail == e.nf, {e.tag, " nf_fail"}, 64'(rsp_nf_fail), 64'(e.nf));
        chk(rsp_walk_req == e.walk, {e.tag, " R9 walk"}, 64'(rsp_walk_req), 64'(e.walk));
        chk(rsp_eff_addr == e.eff, "R10 eff_addr", rsp_eff_addr, e.eff);
        chk(rsp_unchecked == e.unch, "R11 unchecked", 64'(rsp_unchecked), 64'(e.unch));
        chk(rsp_asid == e.asid, "R12 asid", 64'(rsp_asid), 64'(e.asid));
        if (e.walk)
          chk(rsp_start_lvl == e.lvl, "R13 start level", 64'(rsp_start_lvl), 64'(e.lvl));
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  localparam bit [63:0] LO_VA = 64'h0000_1234_5678_9000;
  localparam bit [63:0] HI_VA = 64'hFFFF_8000_0000_1000;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_user = 1'b0;
    req_fetch = 1'b0; req_nonfault = 1'b0; tlb_hit = 1'b0; tcw = '0;
    lo_asid = '0; hi_asid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 1'b0, "R1 reset valid", 64'(rsp_valid), 64'd0);
    chk({rsp_fault_l0, rsp_fault_walkoff, rsp_nf_fail, rsp_walk_req} == 4'b0,
        "R1 reset outcomes", 64'({rsp_fault_l0, rsp_fault_walkoff, rsp_nf_fail, rsp_walk_req}), 64'd0);
    chk(rsp_eff_addr == 64'd0, "R1 reset address", rsp_eff_addr, 64'd0);
    mon_on = 1'b1;

    // R2 R3 R13: basic walks in both regions, back-to-back
    send(LO_VA, mkcw(rg(16, 2'b00), rg(16, 2'b10)), "R9");
    send(HI_VA, mkcw(rg(16, 2'b00), rg(16, 2'b10)), "R9");
    idle(2);
    // R3: every granule code of both regions
    send(LO_VA, mkcw(rg(16, 2'b01), rg(16, 2'b10)), "R3");
    send(LO_VA, mkcw(rg(16, 2'b10), rg(16, 2'b10)), "R3");
    send(LO_VA, mkcw(rg(16, 2'b11), rg(16, 2'b10)), "R3");
    send(HI_VA, mkcw(rg(16, 2'b00), rg(16, 2'b01)), "R3");
    send(HI_VA, mkcw(rg(16, 2'b00), rg(16, 2'b11)), "R3");
    send(HI_VA, mkcw(rg(16, 2'b00), rg(16, 2'b00)), "R3");
    idle(1);
    // R4: size limit follows large-address mode; R13 level -1 and level 1
    send(64'h0000_0000_0000_1000, mkcw(rg(12, 2'b00), rg(16, 2'b10), 0), "R4");
    send(64'h0000_0000_0000_1000, mkcw(rg(12, 2'b00), rg(16, 2'b10), 1), "R4 R13");
    send(64'h0000_0000_0000_1000, mkcw(rg(15, 2'b00), rg(16, 2'b10), 0), "R4");
    send(64'h0000_0000_0000_1000, mkcw(rg(17, 2'b10), rg(16, 2'b10)), "R13");
    send(64'h0000_0000_0000_1000, mkcw(rg(16, 2'b10), rg(16, 2'b10)), "R13");
    send(64'h0000_0000_0000_1000, mkcw(rg(16, 2'b01), rg(16, 2'b10)), "R13");
    idle(1);
    // R5: bits above the region
    send(64'h0004_0000_0000_1000, mkcw(rg(16, 2'b00), rg(16, 2'b10)), "R5");
    send(64'h0004_0000_0000_1000, mkcw(rg(14, 2'b00), rg(16, 2'b10), 1), "R5");
    send(64'hFFFF_7000_0000_1000, mkcw(rg(16, 2'b00), rg(25, 2'b10)), "R5");
    // R10: top-byte ignore, data-only qualifier
    send(64'h5A00_0000_0000_1000, mkcw(rg(16, 2'b00, .tbi(0)), rg(16, 2'b10)), "R5 R10");
    send(64'h5A00_0000_0000_1000, mkcw(rg(16, 2'b00, .tbi(1)), rg(16, 2'b10)), "R10");
    send(64'h5A00_0000_0000_1000, mkcw(rg(16, 2'b00, .tbi(1), .donly(1)), rg(16, 2'b10)), "R10", .fch(1));
    send(64'h5A00_0000_0000_1000, mkcw(rg(16, 2'b00, .tbi(1), .donly(1)), rg(16, 2'b10)), "R10", .fch(0));
    send(64'h12FF_8000_0000_2000, mkcw(rg(16, 2'b00), rg(16, 2'b10, .tbi(1))), "R10", .fch(1));
    idle(1);
    // R6: user fault, identical result on hit and miss
    send(HI_VA, mkcw(rg(16, 2'b00), rg(16, 2'b10, .ufl(1))), "R6", .usr(1), .hit(0));
    send(HI_VA, mkcw(rg(16, 2'b00), rg(16, 2'b10, .ufl(1))), "R6", .usr(1), .hit(1));
    send(HI_VA, mkcw(rg(16, 2'b00), rg(16, 2'b10, .ufl(1))), "R6", .usr(0), .hit(0));
    // R7: walk disabled
    send(LO_VA, mkcw(rg(16, 2'b00, .wo(1)), rg(16, 2'b10)), "R7", .hit(0));
    send(LO_VA, mkcw(rg(16, 2'b00, .wo(1)), rg(16, 2'b10)), "R7", .hit(1));
    send(LO_VA, mkcw(rg(16, 2'b00, .wo(1), .ufl(1)), rg(16, 2'b10)), "R7 R9", .usr(1));
    // R8: non-fault timing
    send(LO_VA, mkcw(rg(16, 2'b00, .nf(1)), rg(16, 2'b10)), "R8", .usr(1), .nfl(1));
    send(LO_VA, mkcw(rg(16, 2'b00, .nf(1)), rg(16, 2'b10)), "R8", .usr(1), .nfl(1), .hit(1));
    send(LO_VA, mkcw(rg(16, 2'b00, .nf(1)), rg(16, 2'b10)), "R8", .usr(0), .nfl(1));
    send(LO_VA, mkcw(rg(16, 2'b00, .nf(1)), rg(16, 2'b10)), "R8", .usr(1), .nfl(0));
    idle(2);
    // R11: tag-check override
    send(64'h0000_0000_0000_4000, mkcw(rg(16, 2'b00, .tov(1)), rg(16, 2'b10)), "R11");
    send(64'h0100_0000_0000_4000, mkcw(rg(16, 2'b00, .tbi(1), .tov(1)), rg(16, 2'b10)), "R11");
    send(HI_VA, mkcw(rg(16, 2'b00), rg(16, 2'b10, .tov(1))), "R11");
    send(64'h0000_0000_0000_4000, mkcw(rg(16, 2'b00, .tov(0)), rg(16, 2'b10)), "R11");
    // R12: ASID selection and width
    send(LO_VA, mkcw(rg(16, 2'b00), rg(16, 2'b10), 0, 0, 1), "R12");
    send(LO_VA, mkcw(rg(16, 2'b00), rg(16, 2'b10), 0, 1, 1), "R12");
    send(LO_VA, mkcw(rg(16, 2'b00), rg(16, 2'b10), 0, 1, 0), "R12");
    send(LO_VA, mkcw(rg(16, 2'b00), rg(16, 2'b10), 0, 0, 0), "R12", .la(16'hFE77));
    idle(3);
    // R1: every request answered exactly once
    chk(q.size() == 0, "R1 outstanding responses", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule